// File: doc/BRIEF.md
# Vertical-Blanking Payload Inserter

This block sits in a video source pipeline that sends embedded-sync 4:2:2 video, one sample per clock. It watches the sync-code lane for timing references: the three-byte preamble FF 00 00 followed by a status byte. From these it learns which lines are vertical-blanking lines. On those lines it replaces the blanking samples between the start-of-line code and the next end-of-line code with bytes pulled from a FIFO-style payload source. Each frame's count of inserted bytes is held on an output.

The receiver loses blanking lines if it finds a false preamble in the data, or if the sample right before an end-of-line code is 00h or FFh. So every payload byte is clipped into 01h..FEh, and the last sample before every end-of-line code is clipped the same way on every line. When the source runs dry, plain blanking levels fill the gap. With two lanes (luma, chroma) only the lane chosen for sync detection carries payload. With one lane the 4:2:2 multiplex carries payload bytes in their original order.

A line-region state machine tracks three states: `RG_HBLANK` (after an end-of-line code), `RG_ACTIVE` (after a start-of-line code with the blanking flag clear) and `RG_VBI` (after a start-of-line code with the blanking flag set). An end-of-line code moves any state to `RG_HBLANK`. A start-of-line code moves any state to `RG_VBI` or `RG_ACTIVE`, depending on the blanking flag. A four-slot look-ahead delay line lets the block see an end-of-line code arrive before the sample in front of it leaves.

Top module: `vbi_inserter`

## Requirements
- R1: A timing reference is FF, 00, 00 then a status byte with bit 7 = 1, bit 5 = vertical-blanking flag and bit 4 = end-of-line flag (1 = end of line, 0 = start of line), all on the sync lane. Only samples after a start-of-line code with bit 5 = 1, up to the next code, take payload.
- R2: A payload byte 00h is written as 01h and FFh is written as FEh. Other values pass unchanged.
- R3: All four code bytes, horizontal-blanking samples and active-line samples leave unchanged, except as R5 states.
- R4: With the source empty, a blanking-line sample becomes a fill value. With two lanes this is 10h on lane 0 and 80h on lane 1. With one lane it is 80h at even positions after the start-of-line code (the first is position 0) and 10h at odd positions.
- R5: On every line, the sync-lane sample immediately before an end-of-line code leaves with 00h changed to 01h and FFh changed to FEh.
- R6: With two lanes, payload and fill go only on the lane picked by `sync_sel` (0 = lane 0, 1 = lane 1). The other lane passes unchanged.
- R7: With one lane, codes and payload use lane 0 and `sync_sel` has no effect. Each blanking-line sample takes the next payload byte in order.
- R8: `pay_ready_o` is high exactly while a blanking-line sample sits at the output stage. A byte is consumed when `pay_ready_o` and `pay_valid_i` are both high at a clock edge.
- R9: At a start-of-line code with bit 5 = 0 that follows a start-of-line code with bit 5 = 1, `vbi_count_o` takes the number of bytes consumed since the last such point. At all other times it holds.
- R10: A sample captured at clock edge n appears on the outputs after edge n+4.
- R11: During reset both video outputs are 00h, `vbi_count_o` is 0 and `pay_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_sel | input | 1 | Lane carrying sync codes and payload (two-lane build only) |
| vid_l0_i | input | 8 | Lane 0 input sample (luma, or the whole multiplex with one lane) |
| vid_l1_i | input | 8 | Lane 1 input sample (chroma) |
| pay_data_i | input | 8 | Payload byte at the head of the source |
| pay_valid_i | input | 1 | Source holds a byte |
| pay_ready_o | output | 1 | Byte consumed this cycle if valid |
| vid_l0_o | output | 8 | Lane 0 output sample |
| vid_l1_o | output | 8 | Lane 1 output sample |
| vbi_count_o | output | CNT_W | Bytes inserted in the last blanking period |

## Verification
Full frames are streamed with the sync lane on lane 0, on lane 1, and with the single-lane build. Comparing these shows whether payload and fill land only on the chosen lane and follow the multiplex parity. A payload list that opens with FF 00 00 FF 00 separates clipping from plain copying. A source that runs dry partway through a line shows the switch to fill values. Active lines ending in 00h, FFh and a neutral value, with 00h and FFh mid-line, show whether the guard touches only the sample in front of an end-of-line code. Two frames with different payload counts show that the count is latched per frame and restarts.

// File: rtl/vbi_ins_pkg.sv
package vbi_ins_pkg;
    localparam int PRE_LEN  = 3;      // FF 00 00 preamble bytes
    localparam int XY_V_BIT = 5;
    localparam int XY_H_BIT = 4;
    localparam int XY_M_BIT = 7;
    localparam logic [7:0] FILL_LUMA   = 8'h10;
    localparam logic [7:0] FILL_CHROMA = 8'h80;

    typedef enum logic [1:0] {
        TAG_HBL  = 2'd0,
        TAG_ACT  = 2'd1,
        TAG_VBI  = 2'd2,
        TAG_CODE = 2'd3
    } tag_e;

    typedef enum logic [1:0] {
        RG_HBLANK = 2'd0,
        RG_ACTIVE = 2'd1,
        RG_VBI    = 2'd2
    } region_e;

    typedef struct packed {
        logic [7:0] l0;
        logic [7:0] l1;
        tag_e       tag;
        logic       odd;
    } slot_t;

    // Keep a byte away from both preamble values.
    function automatic logic [7:0] keep_safe(input logic [7:0] b);
        logic [7:0] r;
        case (b)
            8'h00:   r = 8'h01;
            8'hFF:   r = 8'hFE;
            default: r = b;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/vbi_ins_delay.sv
module vbi_ins_delay
    import vbi_ins_pkg::*;
#(
    parameter int DEPTH = PRE_LEN + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  slot_t                 in_slot,
    input  logic                  retag,
    output slot_t [DEPTH-1:0]     taps
);
    slot_t [DEPTH-1:0] nxt;

    // When a status byte arrives, the preamble bytes already held
    // are marked as code so they never take payload.
    always_comb begin
        nxt[0] = in_slot;
        for (int i = 1; i < DEPTH; i++) begin
            nxt[i] = taps[i-1];
            if (retag && (i <= PRE_LEN)) begin
                nxt[i].tag = TAG_CODE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taps <= '0;
        end else begin
            taps <= nxt;
        end
    end
endmodule

// File: rtl/vbi_ins_tracker.sv
module vbi_ins_tracker
    import vbi_ins_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cur_byte,
    input  logic [7:0] p0,
    input  logic [7:0] p1,
    input  logic [7:0] p2,
    output tag_e       cur_tag,
    output logic       cur_odd,
    output logic       code_hit,
    output logic       eav_hit,
    output logic       frame_end,
    output region_e    region
);
    region_e region_q, region_d;
    logic    seen_q, seen_d;
    logic    odd_q;
    logic    sav_hit, vflag;

    assign code_hit = (p2 == 8'hFF) && (p1 == 8'h00) && (p0 == 8'h00)
                      && cur_byte[XY_M_BIT];
    assign eav_hit  = code_hit && cur_byte[XY_H_BIT];
    assign sav_hit  = code_hit && !cur_byte[XY_H_BIT];
    assign vflag    = cur_byte[XY_V_BIT];
    assign region   = region_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            region_q <= RG_HBLANK;
            seen_q   <= 1'b0;
            odd_q    <= 1'b0;
        end else begin
            region_q <= region_d;
            seen_q   <= seen_d;
            odd_q    <= code_hit ? 1'b0 : ~odd_q;
        end
    end

    // Next state and outputs
    always_comb begin
        region_d  = region_q;
        seen_d    = seen_q;
        frame_end = 1'b0;
        cur_odd   = code_hit ? 1'b0 : odd_q;
        unique case (region_q)
            RG_HBLANK: begin
                if (sav_hit) region_d = vflag ? RG_VBI : RG_ACTIVE;
            end
            RG_ACTIVE, RG_VBI: begin
                if (eav_hit)      region_d = RG_HBLANK;
                else if (sav_hit) region_d = vflag ? RG_VBI : RG_ACTIVE;
            end
            default: region_d = RG_HBLANK;
        endcase
        if (sav_hit) begin
            if (vflag) begin
                seen_d = 1'b1;
            end else if (seen_q) begin
                frame_end = 1'b1;
                seen_d    = 1'b0;
            end
        end
        if (code_hit) begin
            cur_tag = TAG_CODE;
        end else begin
            unique case (region_q)
                RG_ACTIVE: cur_tag = TAG_ACT;
                RG_VBI:    cur_tag = TAG_VBI;
                default:   cur_tag = TAG_HBL;
            endcase
        end
    end
endmodule

// File: rtl/vbi_inserter.sv
module vbi_inserter
    import vbi_ins_pkg::*;
#(
    parameter int DUAL_LANE = 1,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_sel,
    input  logic [7:0]       vid_l0_i,
    input  logic [7:0]       vid_l1_i,
    input  logic [7:0]       pay_data_i,
    input  logic             pay_valid_i,
    output logic             pay_ready_o,
    output logic [7:0]       vid_l0_o,
    output logic [7:0]       vid_l1_o,
    output logic [CNT_W-1:0] vbi_count_o
);
    localparam int DEPTH = PRE_LEN + 1;

    slot_t [DEPTH-1:0] taps;
    slot_t             in_slot, tail;
    tag_e              cur_tag;
    region_e           region;
    logic              cur_odd, code_hit, eav_hit, frame_end;
    logic              eff_sel, take;
    logic [7:0]        in_sync, tail_sync, new_sync, fill_byte;
    logic [CNT_W-1:0]  cnt_q, take_ext;

    assign eff_sel = (DUAL_LANE != 0) && sync_sel;
    assign in_sync = eff_sel ? vid_l1_i : vid_l0_i;
    assign in_slot = '{l0: vid_l0_i, l1: vid_l1_i, tag: cur_tag, odd: cur_odd};
    assign tail    = taps[DEPTH-1];

    vbi_ins_tracker u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_byte  (in_sync),
        .p0        (eff_sel ? taps[0].l1 : taps[0].l0),
        .p1        (eff_sel ? taps[1].l1 : taps[1].l0),
        .p2        (eff_sel ? taps[2].l1 : taps[2].l0),
        .cur_tag   (cur_tag),
        .cur_odd   (cur_odd),
        .code_hit  (code_hit),
        .eav_hit   (eav_hit),
        .frame_end (frame_end),
        .region    (region)
    );

    vbi_ins_delay #(.DEPTH(DEPTH)) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_slot (in_slot),
        .retag   (code_hit),
        .taps    (taps)
    );

    // Output stage: payload / fill on blanking lines, guard before EAV.
    always_comb begin
        tail_sync   = eff_sel ? tail.l1 : tail.l0;
        fill_byte   = (DUAL_LANE != 0) ? (eff_sel ? FILL_CHROMA : FILL_LUMA)
                                       : (tail.odd ? FILL_LUMA : FILL_CHROMA);
        pay_ready_o = (tail.tag == TAG_VBI);
        take        = pay_ready_o && pay_valid_i;
        take_ext    = {{(CNT_W-1){1'b0}}, take};
        if (tail.tag == TAG_VBI) begin
            new_sync = pay_valid_i ? keep_safe(pay_data_i) : fill_byte;
        end else begin
            new_sync = tail_sync;
        end
        if (eav_hit) begin
            new_sync = keep_safe(new_sync);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vid_l0_o    <= '0;
            vid_l1_o    <= '0;
            cnt_q       <= '0;
            vbi_count_o <= '0;
        end else begin
            vid_l0_o <= eff_sel ? tail.l0 : new_sync;
            vid_l1_o <= eff_sel ? new_sync : tail.l1;
            if (frame_end) begin
                vbi_count_o <= cnt_q + take_ext;
                cnt_q       <= '0;
            end else begin
                cnt_q       <= cnt_q + take_ext;
            end
        end
    end
endmodule

// File: rtl/vbi_ins_chk.sv
module vbi_ins_chk
    import vbi_ins_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eff_sel,
    input logic [7:0]       vid_l0_o,
    input logic [7:0]       vid_l1_o,
    input logic             pay_ready_o,
    input logic             pay_valid_i,
    input region_e          region,
    input logic             eav_hit,
    input logic             frame_end,
    input logic [CNT_W-1:0] vbi_count_o,
    input tag_e             tail_tag,
    input logic [7:0]       tail_sync
);
    logic [7:0] out_sync;
    assign out_sync = eff_sel ? vid_l1_o : vid_l0_o;

    // R2
    pop_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_ready_o && pay_valid_i) |=> (out_sync != 8'h00 && out_sync != 8'hFF));

    // R5
    pre_eav_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eav_hit |=> (out_sync != 8'h00 && out_sync != 8'hFF));

    // R3
    code_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_tag == TAG_CODE) |=> (out_sync == $past(tail_sync)));

    // R8
    ready_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready_o |-> (region != RG_ACTIVE));

    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(vbi_count_o));
endmodule

bind vbi_inserter vbi_ins_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .eff_sel     (eff_sel),
    .vid_l0_o    (vid_l0_o),
    .vid_l1_o    (vid_l1_o),
    .pay_ready_o (pay_ready_o),
    .pay_valid_i (pay_valid_i),
    .region      (region),
    .eav_hit     (eav_hit),
    .frame_end   (frame_end),
    .vbi_count_o (vbi_count_o),
    .tail_tag    (tail.tag),
    .tail_sync   (tail_sync)
);

// File: tb/vbi_inserter_test.sv
module vbi_inserter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_sel = 1'b0;
    logic [7:0] vl0 = 8'h10, vl1 = 8'h80;
    logic [7:0] o_l0, o_l1, o8_l0, o8_l1;
    logic [15:0] cnt16, cnt8;
    logic rdy16, rdy8, pay_valid, mode8 = 1'b0, fifo_clr = 1'b1;
    logic [7:0] pay_data;
    logic [7:0] pl_mem [0:255];
    int pl_len = 0, rd_ptr = 0;
    int checks = 0, fails = 0;

    logic [7:0] in0 [0:1023], in1 [0:1023], ex0 [0:1023], ex1 [0:1023];
    int slen, mptr, mcount, mlatched, lpos;
    bit bsel, seen_v;

    always #10 clk = ~clk;

    assign pay_valid = (rd_ptr < pl_len);
    assign pay_data  = pl_mem[rd_ptr[7:0]];

    always @(posedge clk) begin
        if (fifo_clr) rd_ptr <= 0;
        else if (pay_valid && (mode8 ? rdy8 : rdy16)) rd_ptr <= rd_ptr + 1;
    end

    vbi_inserter #(.DUAL_LANE(1)) uut (
        .clk(clk), .rst_n(rst_n), .sync_sel(sync_sel), .vid_l0_i(vl0), .vid_l1_i(vl1),
        .pay_data_i(pay_data), .pay_valid_i(pay_valid), .pay_ready_o(rdy16),
        .vid_l0_o(o_l0), .vid_l1_o(o_l1), .vbi_count_o(cnt16));

    vbi_inserter #(.DUAL_LANE(0)) uut8 (
        .clk(clk), .rst_n(rst_n), .sync_sel(sync_sel), .vid_l0_i(vl0), .vid_l1_i(vl1),
        .pay_data_i(pay_data), .pay_valid_i(pay_valid), .pay_ready_o(rdy8),
        .vid_l0_o(o8_l0), .vid_l1_o(o8_l1), .vbi_count_o(cnt8));

    function automatic logic [7:0] safe(input logic [7:0] b);
        return (b == 8'h00) ? 8'h01 : (b == 8'hFF) ? 8'hFE : b;
    endfunction

    function automatic logic [7:0] mkxy(input bit v, input bit h);
        return {1'b1, 1'b0, v, h, v ^ h, h, 1'b0, v ^ h};
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] s_in, input logic [7:0] s_ex);
        logic [7:0] o;
        o = 8'h20 + 8'(slen % 64);
        if (bsel) begin in1[slen] = s_in; ex1[slen] = s_ex; in0[slen] = o; ex0[slen] = o; end
        else      begin in0[slen] = s_in; ex0[slen] = s_ex; in1[slen] = o; ex1[slen] = o; end
        slen++;
    endtask

    task automatic add_code(input bit v, input bit h);
        if (h && slen > 0) begin
            if (bsel) ex1[slen-1] = safe(ex1[slen-1]);
            else      ex0[slen-1] = safe(ex0[slen-1]);
        end
        put(8'hFF, 8'hFF); put(8'h00, 8'h00); put(8'h00, 8'h00); put(mkxy(v, h), mkxy(v, h));
        lpos = 0;
        if (!h) begin
            if (v) seen_v = 1;
            else if (seen_v) begin mlatched = mcount; mcount = 0; seen_v = 0; end
        end
    endtask

    task automatic add_plain(input int n, input logic [7:0] base);
        for (int k = 0; k < n; k++) put(base + 8'(k), base + 8'(k));
    endtask

    task automatic add_vbi(input int n);
        logic [7:0] e;
        for (int k = 0; k < n; k++) begin
            if (mptr < pl_len) begin e = safe(pl_mem[mptr]); mptr++; mcount++; end
            else if (mode8) e = (lpos % 2 == 1) ? 8'h10 : 8'h80;
            else e = bsel ? 8'h80 : 8'h10;
            put(8'h10, e);
            lpos++;
        end
    endtask

    task automatic vbi_line(input int n);
        add_code(1, 1); add_plain(3, 8'h40); add_code(1, 0); add_vbi(n);
    endtask

    task automatic act_line(input int n, input logic [7:0] last);
        add_code(0, 1); add_plain(3, 8'h40); add_code(0, 0);
        add_plain(n, 8'h60); put(8'h00, 8'h00); put(8'hFF, 8'hFF); put(last, last);
    endtask

    task automatic start_case(input bit m8, input bit sel, input int plen);
        @(negedge clk);
        rst_n = 0; fifo_clr = 1; mode8 = m8; sync_sel = sel; pl_len = plen;
        vl0 = 8'h10; vl1 = 8'h80;
        slen = 0; mptr = 0; mcount = 0; mlatched = 0; lpos = 0; seen_v = 0;
        bsel = m8 ? 1'b0 : sel;
        repeat (2) @(negedge clk);
        rst_n = 1; fifo_clr = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_stream(input string req);
        int bad;
        logic [7:0] a0, a1;
        bad = 0;
        for (int j = 0; j < slen + 5; j++) begin
            @(negedge clk);
            if (j >= 5) begin
                a0 = mode8 ? o8_l0 : o_l0;
                a1 = mode8 ? o8_l1 : o_l1;
                if (a0 !== ex0[j-5] || a1 !== ex1[j-5]) begin
                    if (bad == 0)
                        $display("FAIL %s sample %0d: actual %h/%h expected %h/%h",
                                 req, j-5, a0, a1, ex0[j-5], ex1[j-5]);
                    bad++;
                end
            end
            if (j < slen) begin vl0 = in0[j]; vl1 = in1[j]; end
            else begin vl0 = 8'h10; vl1 = 8'h80; end
        end
        checks++;
        if (bad != 0) fails++;
    endtask

    task automatic close_frame(input string req);
        add_code(0, 1); add_plain(4, 8'h40);
        run_stream(req);
        chk((mode8 ? cnt8 : cnt16) == 16'(mlatched), "R9", "latched count",
            mode8 ? cnt8 : cnt16, mlatched);
        chk(rd_ptr == mptr, "R8", "bytes consumed", rd_ptr, mptr);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk(o_l0 == 8'h00 && o8_l0 == 8'h00, "R11", "lane 0 in reset", o_l0, 0);
        chk(o_l1 == 8'h00 && o8_l1 == 8'h00, "R11", "lane 1 in reset", o_l1, 0);
        chk(cnt16 == 16'd0 && cnt8 == 16'd0, "R11", "count in reset", cnt16, 0);
        chk(!rdy16 && !rdy8, "R11", "ready in reset", rdy16, 0);
    endtask

    task automatic t_latency();
        int seen_at;
        start_case(0, 0, 0);
        seen_at = -1;
        vl0 = 8'h5A;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            vl0 = 8'h10;
            if (o_l0 == 8'h5A && seen_at < 0) seen_at = k;
        end
        chk(seen_at == 5, "R10", "latency in half-cycle-sampled slots", seen_at, 5);
    endtask

    task automatic t_luma_lane();
        for (int k = 0; k < 256; k++) pl_mem[k] = 8'(k * 53 + 7);
        pl_mem[0] = 8'hFF; pl_mem[1] = 8'h00; pl_mem[2] = 8'h00; pl_mem[3] = 8'hFF; pl_mem[4] = 8'h00;
        start_case(0, 0, 200);
        vbi_line(12); vbi_line(12); vbi_line(12);
        act_line(6, 8'h55); act_line(6, 8'h56);
        close_frame("R1 R2 R3 R6 R10 lane0");
    endtask

    task automatic t_chroma_lane();
        for (int k = 0; k < 256; k++) pl_mem[k] = 8'(k * 29 + 3);
        pl_mem[2] = 8'hFF;
        start_case(0, 1, 15);
        vbi_line(10); vbi_line(10);
        act_line(4, 8'h33);
        close_frame("R4 R6 lane1 partial source");
    endtask

    task automatic t_guard();
        start_case(0, 0, 0);
        vbi_line(6);
        act_line(5, 8'h00); act_line(5, 8'hFF); act_line(5, 8'h7F);
        close_frame("R5 R3 pre-EAV guard");
    endtask

    task automatic t_narrow();
        for (int k = 0; k < 256; k++) pl_mem[k] = 8'(k * 17 + 1);
        pl_mem[1] = 8'h00;
        start_case(1, 1, 9);
        vbi_line(8); vbi_line(8);
        act_line(4, 8'h44);
        close_frame("R7 R4 single lane");
    endtask

    task automatic t_two_frames();
        for (int k = 0; k < 256; k++) pl_mem[k] = 8'(k + 8'h30);
        start_case(0, 1, 100);
        vbi_line(6); vbi_line(6); act_line(3, 8'h21);
        vbi_line(5); act_line(3, 8'h22);
        close_frame("R9 second frame");
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_luma_lane();
        t_chroma_lane();
        t_guard();
        t_narrow();
        t_two_frames();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule